// File: doc/BRIEF.md
# Programmable Synchronous Strobe Timing Generator

This block generates the control strobes for one access to a synchronous external memory: chip select, address valid, output enable and write enable, all active low, together with a bus clock derived from the functional clock. A start request launches an access. The read/write select and the number of additional burst beats are captured when the request is accepted. From then on a position counter advances once per functional clock, and each strobe is held low between two computed edge positions.

Each edge position starts from a programmed time value. For burst accesses the value is lengthened by the page time for each additional beat. It is then scaled by a granularity factor, and a small alignment delay moves it onto the phase of the divided bus clock. The bus clock itself begins toggling only at a programmable activation position. Any strobe can also be postponed by half a functional clock. The access ends after a programmed cycle length, and a one-cycle done pulse marks the end.

The timing fields and divider settings are assumed to stay static during an access.

Top module: `sync_strobe_gen`

## Requirements
- R1: After reset and whenever no access is running, cs_n, adv_n, oe_n and we_n are high, bus_clk is low, and active and done are low.
- R2: A start is accepted only while active is low, and the accepting rising edge is position 0. A start that arrives during an access changes nothing: the strobe positions, the access length and the captured is_write and burst_extra values all stay as they were.
- R3: Let x be burst_extra and g be gran. An access lasts L = (cycle + x*page_time)*(g+1) positions, where cycle is wr_cycle for a write and rd_cycle for a read. active is high for positions 0 to L-1. done is high for exactly one cycle, in the cycle that follows position L-1, and active is low in that cycle.
- R4: A strobe is low at position k when Eon <= k < Eoff. Each edge position is E = v*(g+1) + align(v). For the on edges, v is the programmed on time. For the off edges of chip select, output enable and write enable, v is the programmed off time plus x*page_time. The address-valid off edge is not lengthened by the burst.
- R5: Let D = div_code+1. The alignment delay is align(v) = ((v mod D) - (clk_act mod D)) mod D. With D = 1 it is always 0.
- R6: Bits 0, 1, 2 and 3 of half_dly select a half-functional-clock postponement of both edges of cs_n, adv_n, oe_n and we_n respectively.
- R7: bus_clk is low before position clk_act. From that position on, with D = 1 it follows the functional clock. With D > 1 it is high at positions where (k - clk_act) mod D < D/2 (integer division), and low at the other positions.
- R8: A read uses the read off times of chip select and address valid and pulses only oe_n. A write uses the write off times and pulses only we_n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Access request |
| is_write | input | 1 | 1 selects a write, 0 a read; captured at acceptance |
| burst_extra | input | BEAT_W | Number of beats minus one; captured at acceptance |
| gran | input | 1 | Granularity: 1 doubles every programmed time |
| div_code | input | 2 | Bus clock divide ratio minus one |
| clk_act | input | TIME_W | Bus clock activation position |
| half_dly | input | 4 | Per-strobe half-cycle delay enables |
| cs_on | input | TIME_W | Chip select assert time |
| cs_rd_off | input | TIME_W | Chip select release time, reads |
| cs_wr_off | input | TIME_W | Chip select release time, writes |
| adv_on | input | TIME_W | Address valid assert time |
| adv_rd_off | input | TIME_W | Address valid release time, reads |
| adv_wr_off | input | TIME_W | Address valid release time, writes |
| oe_on | input | TIME_W | Output enable assert time |
| oe_off | input | TIME_W | Output enable release time |
| we_on | input | TIME_W | Write enable assert time |
| we_off | input | TIME_W | Write enable release time |
| rd_cycle | input | TIME_W | Read access length |
| wr_cycle | input | TIME_W | Write access length |
| page_time | input | TIME_W | Extra length for each additional burst beat |
| cs_n | output | 1 | Chip select, active low |
| adv_n | output | 1 | Address valid, active low |
| oe_n | output | 1 | Output enable, active low |
| we_n | output | 1 | Write enable, active low |
| bus_clk | output | 1 | Divided bus clock |
| done | output | 1 | One-cycle end-of-access pulse |
| active | output | 1 | Access in progress |

## Verification
The levels for position k appear just after the k-th rising edge, where the accepting edge is position 0. A strobe with its half delay set shows the new level only after the following falling edge. done rises one edge after position L-1, and with a divide ratio of 1 bus_clk is high only in the first half of each functional clock. For every position of an access the scoreboard queues two expected records, one for 2 ns and one for 7 ns after the rising edge. It also queues records for the done cycle and one idle cycle. The monitor pops one record at each of those two instants, so both the undelayed level and the half-cycle-delayed level are checked at every position.

// File: rtl/stg_pkg.sv
// Shared constants for the strobe timing generator.
// Assumes four strobes indexed in a fixed order used by half_dly.
package stg_pkg;
    localparam int STB_N   = 4;
    localparam int STB_CS  = 0;
    localparam int STB_ADV = 1;
    localparam int STB_OE  = 2;
    localparam int STB_WE  = 3;
    // Off edges that grow with extra burst beats (address valid does not)
    localparam logic [STB_N-1:0] OFF_STRETCH = 4'b1101;
endpackage

// File: rtl/stg_edge_pos.sv
// Converts one programmed time value into an edge position in functional
// clocks: optional burst lengthening, granularity scaling and alignment to
// the divided bus clock phase. Assumes inputs static during an access.
module stg_edge_pos #(
    parameter int TIME_W = 6,
    parameter int BEAT_W = 3,
    localparam int VAL_W = TIME_W + BEAT_W,
    localparam int CNT_W = VAL_W + 1
) (
    input  logic [TIME_W-1:0] prog,
    input  logic [BEAT_W-1:0] beats_x,
    input  logic [TIME_W-1:0] page_time,
    input  logic              stretch,
    input  logic              gran,
    input  logic [1:0]        div_code,
    input  logic [TIME_W-1:0] clk_act,
    output logic [CNT_W-1:0]  pos
);
    logic [VAL_W-1:0] val;
    logic [1:0]       m_val, m_act;
    logic [2:0]       ratio, dly;

    // Remainder of x by the divide ratio selected by the code
    function automatic logic [1:0] mod_ratio(input logic [VAL_W-1:0] x,
                                             input logic [1:0] code);
        case (code)
            2'd0:    return 2'd0;
            2'd1:    return {1'b0, x[0]};
            2'd2:    return 2'(x % VAL_W'(3));
            default: return x[1:0];
        endcase
    endfunction

    // Lengthen, align and scale the programmed value
    always_comb begin
        val   = VAL_W'(prog) + (stretch ? VAL_W'(beats_x) * VAL_W'(page_time) : '0);
        m_val = mod_ratio(val, div_code);
        m_act = mod_ratio(VAL_W'(clk_act), div_code);
        ratio = {1'b0, div_code} + 3'd1;
        dly   = {1'b0, m_val} + ratio - {1'b0, m_act};
        if (dly >= ratio) dly = dly - ratio;
        pos   = (gran ? {val, 1'b0} : {1'b0, val}) + CNT_W'(dly);
    end
endmodule

// File: rtl/stg_strobe_pin.sv
// One active-low strobe: low while the next position lies in [on, off),
// registered on the rising edge, with an optional falling-edge retimed copy.
// Assumes on/off positions static during an access.
module stg_strobe_pin #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] next_pos,
    input  logic             run_next,
    input  logic             enable,
    input  logic [CNT_W-1:0] on_pos,
    input  logic [CNT_W-1:0] off_pos,
    input  logic             half,
    output logic             pin_n
);
    logic rise_q, fall_q;

    // Rising-edge strobe level for the coming position
    always_ff @(posedge clk) begin
        if (!rst_n) rise_q <= 1'b1;
        else        rise_q <= !(run_next && enable && next_pos >= on_pos && next_pos < off_pos);
    end

    // Half-cycle retiming of the strobe level
    always_ff @(negedge clk) begin
        if (!rst_n) fall_q <= 1'b1;
        else        fall_q <= rise_q;
    end

    assign pin_n = half ? fall_q : rise_q;

    // R6: with the half delay chosen the pin carries the previous rising-edge level
    assert_half_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        half |-> (pin_n == rise_q));
endmodule

// File: rtl/stg_bus_clk.sv
// Bus clock generator: low until the activation position, then the
// functional clock itself (ratio 1) or a registered divided clock whose
// rising phase is at (position - activation) mod ratio == 0.
// Assumes divider code static during an access.
module stg_bus_clk #(
    parameter int TIME_W = 6,
    parameter int CNT_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  next_pos,
    input  logic              run_next,
    input  logic [TIME_W-1:0] clk_act,
    input  logic [1:0]        div_code,
    output logic              bus_clk
);
    logic [1:0] ph_q, ph_n, high_cnt;
    logic       en_q, div_q, past_act;

    // Phase of the coming position inside the divided period
    always_comb begin
        past_act = next_pos >= CNT_W'(clk_act);
        high_cnt = 2'((3'({1'b0, div_code}) + 3'd1) >> 1);
        if (next_pos <= CNT_W'(clk_act)) ph_n = 2'd0;
        else if (ph_q == div_code)       ph_n = 2'd0;
        else                             ph_n = ph_q + 2'd1;
    end

    // Enable, phase and divided level registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            ph_q  <= 2'd0;
            div_q <= 1'b0;
        end else begin
            en_q  <= run_next && past_act;
            ph_q  <= ph_n;
            div_q <= run_next && past_act && (ph_n < high_cnt);
        end
    end

    assign bus_clk = (div_code == 2'd0) ? (clk & en_q) : div_q;

    // R7: ratio 2 toggles the divided level on every running position
    assert_div2_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (div_code == 2'd1 && en_q && $past(en_q)) |-> (div_q != $past(div_q)));
endmodule

// File: rtl/sync_strobe_gen.sv
// Top of the synchronous strobe timing generator. Accepts a start while
// idle, captures read/write and burst length, runs a position counter over
// the access and drives four strobes plus the bus clock.
// Assumes timing fields static during an access and cycle length >= 1.
module sync_strobe_gen
    import stg_pkg::*;
#(
    parameter int TIME_W = 6,
    parameter int BEAT_W = 3,
    localparam int VAL_W = TIME_W + BEAT_W,
    localparam int CNT_W = VAL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_write,
    input  logic [BEAT_W-1:0] burst_extra,
    input  logic              gran,
    input  logic [1:0]        div_code,
    input  logic [TIME_W-1:0] clk_act,
    input  logic [3:0]        half_dly,
    input  logic [TIME_W-1:0] cs_on,
    input  logic [TIME_W-1:0] cs_rd_off,
    input  logic [TIME_W-1:0] cs_wr_off,
    input  logic [TIME_W-1:0] adv_on,
    input  logic [TIME_W-1:0] adv_rd_off,
    input  logic [TIME_W-1:0] adv_wr_off,
    input  logic [TIME_W-1:0] oe_on,
    input  logic [TIME_W-1:0] oe_off,
    input  logic [TIME_W-1:0] we_on,
    input  logic [TIME_W-1:0] we_off,
    input  logic [TIME_W-1:0] rd_cycle,
    input  logic [TIME_W-1:0] wr_cycle,
    input  logic [TIME_W-1:0] page_time,
    output logic              cs_n,
    output logic              adv_n,
    output logic              oe_n,
    output logic              we_n,
    output logic              bus_clk,
    output logic              done,
    output logic              active
);
    logic              active_q, done_q, rw_q;
    logic [BEAT_W-1:0] bx_q, bx_eff;
    logic [CNT_W-1:0]  t_q, next_pos, acc_len;
    logic [CNT_W:0]    t_inc;
    logic [VAL_W-1:0]  len_base;
    logic              accept, rw_eff, more, finish, run_next;
    logic [TIME_W-1:0] on_p  [STB_N];
    logic [TIME_W-1:0] off_p [STB_N];
    logic [STB_N-1:0]  en_p, pins_n;

    // Acceptance, effective access settings, length and next position
    always_comb begin
        accept   = start && !active_q;
        rw_eff   = accept ? is_write : rw_q;
        bx_eff   = accept ? burst_extra : bx_q;
        len_base = VAL_W'(rw_eff ? wr_cycle : rd_cycle) + VAL_W'(bx_eff) * VAL_W'(page_time);
        acc_len  = gran ? {len_base, 1'b0} : {1'b0, len_base};
        t_inc    = {1'b0, t_q} + 1'b1;
        more     = t_inc < {1'b0, acc_len};
        finish   = active_q && !more;
        run_next = accept || (active_q && more);
        next_pos = accept ? '0 : t_inc[CNT_W-1:0];
    end

    // Per-strobe programmed times and enables for the selected direction
    always_comb begin
        on_p[STB_CS]   = cs_on;
        off_p[STB_CS]  = rw_eff ? cs_wr_off : cs_rd_off;
        on_p[STB_ADV]  = adv_on;
        off_p[STB_ADV] = rw_eff ? adv_wr_off : adv_rd_off;
        on_p[STB_OE]   = oe_on;
        off_p[STB_OE]  = oe_off;
        on_p[STB_WE]   = we_on;
        off_p[STB_WE]  = we_off;
        en_p           = {rw_eff, !rw_eff, 1'b1, 1'b1};
    end

    // Access state: running flag, done pulse, captured settings, position
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q <= 1'b0;
            done_q   <= 1'b0;
            rw_q     <= 1'b0;
            bx_q     <= '0;
            t_q      <= '0;
        end else begin
            active_q <= run_next;
            done_q   <= finish;
            if (accept) begin
                rw_q <= is_write;
                bx_q <= burst_extra;
            end
            if (run_next) t_q <= next_pos;
        end
    end

    // One edge-position pair and one output stage per strobe
    for (genvar i = 0; i < STB_N; i++) begin : g_strobe
        logic [CNT_W-1:0] on_pos, off_pos;

        stg_edge_pos #(.TIME_W(TIME_W), .BEAT_W(BEAT_W)) u_on (
            .prog(on_p[i]), .beats_x(bx_eff), .page_time(page_time),
            .stretch(1'b0), .gran(gran), .div_code(div_code),
            .clk_act(clk_act), .pos(on_pos));

        stg_edge_pos #(.TIME_W(TIME_W), .BEAT_W(BEAT_W)) u_off (
            .prog(off_p[i]), .beats_x(bx_eff), .page_time(page_time),
            .stretch(OFF_STRETCH[i]), .gran(gran), .div_code(div_code),
            .clk_act(clk_act), .pos(off_pos));

        stg_strobe_pin #(.CNT_W(CNT_W)) u_pin (
            .clk(clk), .rst_n(rst_n), .next_pos(next_pos), .run_next(run_next),
            .enable(en_p[i]), .on_pos(on_pos), .off_pos(off_pos),
            .half(half_dly[i]), .pin_n(pins_n[i]));
    end

    stg_bus_clk #(.TIME_W(TIME_W), .CNT_W(CNT_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .next_pos(next_pos), .run_next(run_next),
        .clk_act(clk_act), .div_code(div_code), .bus_clk(bus_clk));

    assign cs_n   = pins_n[STB_CS];
    assign adv_n  = pins_n[STB_ADV];
    assign oe_n   = pins_n[STB_OE];
    assign we_n   = pins_n[STB_WE];
    assign done   = done_q;
    assign active = active_q;

    // R1: no strobe is asserted outside an access
    assert_idle_pins_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !active_q |-> (cs_n && adv_n && oe_n && we_n));

    // R3: done lasts a single cycle
    assert_done_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);

    // R3: the access is over when done is raised
    assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> !active_q);

    // R2: a start during a running access does not restart the counter
    assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (active_q && start && !finish) |=> (t_q == CNT_W'($past(t_q) + 1'b1)));
endmodule

// File: tb/sync_strobe_gen_test.sv
// Scoreboard bench: the driver queues expected levels for every position
// and phase, the monitor samples 2 ns and 7 ns after each rising edge.
module sync_strobe_gen_test;
    localparam int TW = 6;
    localparam int BW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0, is_write = 1'b0, gran = 1'b0;
    logic [BW-1:0] burst_extra = '0;
    logic [1:0] div_code = 2'd0;
    logic [3:0] half_dly = 4'd0;
    logic [TW-1:0] clk_act = '0;
    logic [TW-1:0] cs_on = 6'd1, cs_rd_off = 6'd9, cs_wr_off = 6'd8;
    logic [TW-1:0] adv_on = 6'd1, adv_rd_off = 6'd3, adv_wr_off = 6'd4;
    logic [TW-1:0] oe_on = 6'd3, oe_off = 6'd9, we_on = 6'd2, we_off = 6'd7;
    logic [TW-1:0] rd_cycle = 6'd11, wr_cycle = 6'd10, page_time = 6'd3;
    logic cs_n, adv_n, oe_n, we_n, bus_clk, done, active;

    int errs = 0;
    int checks = 0;

    typedef struct {
        int   k;
        bit   ph;
        logic [3:0] pins;   // {we, oe, adv, cs}
        logic bus;
        logic act;
        logic dn;
    } rec_t;
    rec_t sb[$];

    always #5 clk = ~clk;

    sync_strobe_gen #(.TIME_W(TW), .BEAT_W(BW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .is_write(is_write),
        .burst_extra(burst_extra), .gran(gran), .div_code(div_code),
        .clk_act(clk_act), .half_dly(half_dly),
        .cs_on(cs_on), .cs_rd_off(cs_rd_off), .cs_wr_off(cs_wr_off),
        .adv_on(adv_on), .adv_rd_off(adv_rd_off), .adv_wr_off(adv_wr_off),
        .oe_on(oe_on), .oe_off(oe_off), .we_on(we_on), .we_off(we_off),
        .rd_cycle(rd_cycle), .wr_cycle(wr_cycle), .page_time(page_time),
        .cs_n(cs_n), .adv_n(adv_n), .oe_n(oe_n), .we_n(we_n),
        .bus_clk(bus_clk), .done(done), .active(active));

    // R4 R5: edge position from a programmed value
    function automatic int edge_at(int prog, bit str, int x, int g, int d, int a);
        int v, dr, al;
        v  = prog + (str ? x * int'(page_time) : 0);
        dr = d + 1;
        al = ((v % dr) - (a % dr) + dr) % dr;
        return v * (g + 1) + al;
    endfunction

    // Driver: queue expected records for one access, then launch it
    task automatic run_access(input bit wr, input int g, input int d, input int a,
                              input int x, input logic [3:0] h, input bit poke);
        int len, dr;
        int eon[4];
        int eoff[4];
        bit en[4];
        @(negedge clk);
        #3;
        is_write = wr; gran = g[0]; div_code = d[1:0]; clk_act = TW'(a);
        burst_extra = BW'(x); half_dly = h;
        dr  = d + 1;
        len = (int'(wr ? wr_cycle : rd_cycle) + x * int'(page_time)) * (g + 1);
        eon[0] = edge_at(int'(cs_on), 0, x, g, d, a);
        eoff[0] = edge_at(int'(wr ? cs_wr_off : cs_rd_off), 1, x, g, d, a);
        eon[1] = edge_at(int'(adv_on), 0, x, g, d, a);
        eoff[1] = edge_at(int'(wr ? adv_wr_off : adv_rd_off), 0, x, g, d, a);
        eon[2] = edge_at(int'(oe_on), 0, x, g, d, a);
        eoff[2] = edge_at(int'(oe_off), 1, x, g, d, a);
        eon[3] = edge_at(int'(we_on), 0, x, g, d, a);
        eoff[3] = edge_at(int'(we_off), 1, x, g, d, a);
        en[0] = 1'b1; en[1] = 1'b1; en[2] = !wr; en[3] = wr;
        for (int k = 0; k <= len + 1; k++) begin
            for (int p = 0; p < 2; p++) begin
                rec_t r;
                r.k = k; r.ph = p[0];
                for (int i = 0; i < 4; i++) begin
                    int kk;
                    kk = (h[i] && p == 0) ? k - 1 : k;
                    r.pins[i] = !(kk >= 0 && kk < len && en[i] && kk >= eon[i] && kk < eoff[i]);
                end
                if (k < len && k >= a)
                    r.bus = (dr == 1) ? (p == 0) : (((k - a) % dr) < (dr / 2));
                else
                    r.bus = 1'b0;
                r.act = (k < len);
                r.dn  = (k == len);
                sb.push_back(r);
            end
        end
        start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        if (poke) begin
            // R2: a start while busy with other settings must be ignored
            repeat (2) @(posedge clk);
            #1 start = 1'b1; is_write = !wr; burst_extra = BW'(x + 1);
            @(posedge clk);
            #1 start = 1'b0; is_write = wr; burst_extra = BW'(x);
        end
        while (sb.size() != 0) @(posedge clk);
    endtask

    // Monitor: compare one queued record against the ports
    task automatic compare_now(input bit ph);
        rec_t r;
        logic [3:0] got;
        if (sb.size() == 0) return;
        r = sb.pop_front();
        got = {we_n, oe_n, adv_n, cs_n};
        checks++;
        if (r.ph != ph) begin
            errs++;
            $display("FAIL R3 k=%0d phase order: actual=%0d expected=%0d", r.k, ph, r.ph);
        end else if (got !== r.pins) begin
            errs++;
            $display("FAIL R4,R5,R6,R8 k=%0d ph=%0d strobes{we,oe,adv,cs}: actual=%b expected=%b",
                     r.k, ph, got, r.pins);
        end else if (bus_clk !== r.bus) begin
            errs++;
            $display("FAIL R7 k=%0d ph=%0d bus_clk: actual=%b expected=%b", r.k, ph, bus_clk, r.bus);
        end else if (active !== r.act || done !== r.dn) begin
            errs++;
            $display("FAIL R2,R3 k=%0d ph=%0d {active,done}: actual=%b%b expected=%b%b",
                     r.k, ph, active, done, r.act, r.dn);
        end
    endtask

    // Monitor process: early and late sample after every rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2 compare_now(1'b0);
            #5 compare_now(1'b1);
        end
    end

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        errs++; checks++;
        $display("FAIL R3 watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    // Main sequence
    initial begin
        repeat (3) @(posedge clk);
        #8 rst_n = 1'b1;
        repeat (2) @(posedge clk);
        #3;
        // R1: idle levels after reset
        checks++;
        if ({cs_n, adv_n, oe_n, we_n, bus_clk, active, done} !== 7'b1111000) begin
            errs++;
            $display("FAIL R1 reset idle: actual=%b expected=%b",
                     {cs_n, adv_n, oe_n, we_n, bus_clk, active, done}, 7'b1111000);
        end
        // R4 R8 plain read, ratio 1
        run_access(1'b0, 0, 0, 0, 0, 4'b0000, 1'b0);
        // R5 R6 write, doubled, ratio 2, burst, half delay on cs and we
        run_access(1'b1, 1, 1, 1, 2, 4'b1001, 1'b0);
        // R5 R6 read, ratio 3, one extra beat, half delay on adv and oe
        run_access(1'b0, 0, 2, 1, 1, 4'b0110, 1'b0);
        // R3 R7 read, doubled, ratio 4, long burst
        run_access(1'b0, 1, 3, 2, 3, 4'b0000, 1'b0);
        // R2 write with a start arriving mid-access
        run_access(1'b1, 0, 1, 0, 1, 4'b0000, 1'b1);
        // R7 ratio 1 with late activation, all strobes half delayed
        run_access(1'b0, 0, 0, 3, 0, 4'b1111, 1'b0);
        repeat (3) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule